// File: doc/BRIEF.md
# Two-Way Set-Associative Line Cache

This block is a two-way set-associative data cache placed between a simple processor request port and a main-memory port. A request carries a byte address, a read/write flag, a 32-bit write word and four byte enables. The request is held until the cache raises `req_ready` for one cycle. On a read, `req_rdata` is valid in that same cycle. Each line holds one 4-byte word. The address is divided into a tag in the upper bits, a set index of `SET_BITS` bits in the middle, and a 2-bit byte offset at the bottom. With 13 set bits this gives a 9-bit tag over a 24-bit address. The default configuration is smaller, and the tag width is derived from the set width.

Both ways of the indexed set are compared against the request tag. On a miss, the victim is an empty way, or otherwise the least recently used way of the set. If the victim is dirty it is written back first, and then the whole line is read from memory. Two live control inputs set the mode:
- `cfg_write_back` chooses between write-back with write-allocate and write-through without allocation.
- `cfg_disable` sends every access straight to memory.

Two held commands act on the whole cache:
- `cmd_invalidate` drops every line.
- `cmd_flush` writes every dirty line to memory before dropping them all.

Top module: `c2w_cache`

## Requirements
- R1: After reset `req_ready`, `mem_valid` and `cmd_done` are low and every line is invalid, so the first read of any address fetches its line from memory.
- R2: A read that hits raises `req_ready` in the cycle it is presented, with the stored line on `req_rdata` and no memory transaction. The two ways never both hit.
- R3: A read miss issues one memory read at `{tag, set, 2'b00}` and delivers the fetched line. Address split: offset is bits [1:0], set is bits [SET_BITS+1:2], tag is the rest.
- R4: Two lines with different tags and the same set index are resident at the same time.
- R5: On a miss with both ways valid, the way replaced is the one not most recently hit or filled in that set.
- R6: In write-back mode a write hit updates only the cache (byte enable bit i selects bits 8i+7:8i) and marks the line dirty. A dirty victim is written to memory at its own line address before the fill. A clean victim is not written.
- R7: In write-back mode a write miss first fills the line from memory and then merges the enabled bytes into it, with no memory write.
- R8: In write-through mode every write goes to memory with the request's address, data and byte enables. A hit also updates the cached line. A miss allocates nothing, so a later read of that line misses.
- R9: With `cfg_disable` high every access goes to memory, and lines held in the cache stay unchanged. After the bit is cleared, those lines hit with their earlier contents.
- R10: `cmd_invalidate` clears every line without any memory write, and pulses `cmd_done`.
- R11: `cmd_flush` writes each dirty line to memory at its line address, then clears every line and pulses `cmd_done`. Only memory writes occur during a flush.
- R12: Once `mem_valid` rises, it and `mem_addr` stay unchanged until the cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_disable | input | 1 | Bypass the cache entirely |
| cfg_write_back | input | 1 | 1: write-back with allocate; 0: write-through |
| cmd_invalidate | input | 1 | Clear all lines (held until cmd_done) |
| cmd_flush | input | 1 | Write back dirty lines, then clear all (held until cmd_done) |
| cmd_done | output | 1 | One-cycle completion of a command |
| req_valid | input | 1 | Request present, held until req_ready |
| req_write | input | 1 | 1 for write |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write word |
| req_be | input | 4 | Byte enables |
| req_ready | output | 1 | Request completes this cycle |
| req_rdata | output | 32 | Read word, valid with req_ready |
| mem_valid | output | 1 | Memory transaction pending |
| mem_write | output | 1 | 1 for memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_be | output | 4 | Memory byte enables |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | 32 | Memory read word, valid with mem_ready |

## Verification
The assertions assume that a requester keeps `req_valid`, address, data, enables and the mode bits steady from presentation until `req_ready`. They also assume that a command is held until `cmd_done`, and that commands and requests are not raised together. The memory-hold and single-hit properties depend on these assumptions. The bench drives each access from a task that changes inputs only after a clock edge and releases them right after the completing edge. It changes modes only between accesses. Its memory model answers every transaction after a fixed two-cycle wait.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EVICT = 3'd1,
        ST_FILL  = 3'd2,
        ST_MEMOP = 3'd3,
        ST_FLUSH = 3'd4
    } c2w_state_e;
endpackage

// File: rtl/c2w_way.sv
module c2w_way #(
    parameter int SETS  = 1024,
    parameter int IDX_W = 10,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [31:0]      rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [31:0]      wr_data,
    input  logic [3:0]       wr_be,
    input  logic             wr_dirty,
    input  logic             clr_all
);
    logic [SETS-1:0]  valid_q, dirty_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [31:0]      data_q [SETS];

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            for (int b = 0; b < 4; b++) begin
                if (wr_be[b]) data_q[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    // R10
    wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_q == '0 && dirty_q == '0));
endmodule

// File: rtl/c2w_cache.sv
module c2w_cache
    import c2w_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int SET_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_disable,
    input  logic              cfg_write_back,
    input  logic              cmd_invalidate,
    input  logic              cmd_flush,
    output logic              cmd_done,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              req_ready,
    output logic [31:0]       req_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata
);
    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = ADDR_W - SET_BITS - 2;
    localparam int WAYS  = 2;

    typedef struct packed {
        c2w_state_e      st;
        logic            way;
        logic            wt_hit;
        logic [SET_BITS:0] scan;
        logic [SETS-1:0] lru;
    } regs_t;

    regs_t r_q, r_d;

    logic [SET_BITS-1:0] idx_req, rd_idx, scan_idx;
    logic [TAG_W-1:0]    tag_req;
    logic                scan_way;
    logic [WAYS-1:0]     rd_valid, rd_dirty, hit_w, wr_en;
    logic [TAG_W-1:0]    rd_tag [WAYS];
    logic [31:0]         rd_data [WAYS];
    logic [31:0]         wr_data;
    logic [3:0]          wr_be;
    logic                wr_dirty, clr_all, hit, hit_way, victim;

    assign idx_req  = req_addr[SET_BITS+1:2];
    assign tag_req  = req_addr[ADDR_W-1 -: TAG_W];
    assign scan_idx = r_q.scan[SET_BITS:1];
    assign scan_way = r_q.scan[0];
    assign rd_idx   = (r_q.st == ST_FLUSH) ? scan_idx : idx_req;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        c2w_way #(.SETS(SETS), .IDX_W(SET_BITS), .TAG_W(TAG_W)) u_way (
            .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx),
            .rd_valid(rd_valid[w]), .rd_dirty(rd_dirty[w]),
            .rd_tag(rd_tag[w]), .rd_data(rd_data[w]),
            .wr_en(wr_en[w]), .wr_idx(idx_req), .wr_tag(tag_req),
            .wr_data(wr_data), .wr_be(wr_be), .wr_dirty(wr_dirty),
            .clr_all(clr_all)
        );
        assign hit_w[w] = rd_valid[w] && (rd_tag[w] == tag_req);
    end

    assign hit     = |hit_w;
    assign hit_way = hit_w[1];
    assign victim  = !rd_valid[0] ? 1'b0 : (!rd_valid[1] ? 1'b1 : r_q.lru[idx_req]);

    always_comb begin
        logic adv;
        r_d       = r_q;
        adv       = 1'b0;
        req_ready = 1'b0;
        req_rdata = (r_q.st == ST_MEMOP) ? mem_rdata : rd_data[hit_way];
        cmd_done  = 1'b0;
        clr_all   = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = {tag_req, idx_req, 2'b00};
        mem_wdata = req_wdata;
        mem_be    = 4'hF;
        wr_en     = '0;
        wr_data   = req_wdata;
        wr_be     = req_be;
        wr_dirty  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_flush) begin
                    r_d.st   = ST_FLUSH;
                    r_d.scan = '0;
                end else if (cmd_invalidate) begin
                    clr_all  = 1'b1;
                    cmd_done = 1'b1;
                end else if (req_valid) begin
                    if (cfg_disable) begin
                        r_d.st     = ST_MEMOP;
                        r_d.wt_hit = 1'b0;
                    end else if (req_write && !cfg_write_back) begin
                        r_d.st     = ST_MEMOP;
                        r_d.wt_hit = hit;
                        r_d.way    = hit_way;
                    end else if (hit) begin
                        req_ready          = 1'b1;
                        r_d.lru[idx_req]   = ~hit_way;
                        if (req_write) begin
                            wr_en[hit_way] = 1'b1;
                            wr_dirty       = 1'b1;
                        end
                    end else begin
                        r_d.way = victim;
                        r_d.st  = (rd_valid[victim] && rd_dirty[victim]) ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {rd_tag[r_q.way], idx_req, 2'b00};
                mem_wdata = rd_data[r_q.way];
                if (mem_ready) r_d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    wr_en[r_q.way]   = 1'b1;
                    wr_data          = mem_rdata;
                    wr_be            = 4'hF;
                    r_d.lru[idx_req] = ~r_q.way;
                    r_d.st           = ST_IDLE;
                end
            end
            ST_MEMOP: begin
                mem_valid = 1'b1;
                mem_write = req_write;
                mem_addr  = req_addr;
                mem_be    = req_be;
                if (mem_ready) begin
                    req_ready = 1'b1;
                    r_d.st    = ST_IDLE;
                    if (r_q.wt_hit) begin
                        wr_en[r_q.way]   = 1'b1;
                        wr_dirty         = rd_dirty[r_q.way];
                        r_d.lru[idx_req] = ~r_q.way;
                    end
                end
            end
            ST_FLUSH: begin
                if (rd_valid[scan_way] && rd_dirty[scan_way]) begin
                    mem_valid = 1'b1;
                    mem_write = 1'b1;
                    mem_addr  = {rd_tag[scan_way], scan_idx, 2'b00};
                    mem_wdata = rd_data[scan_way];
                    adv       = mem_ready;
                end else begin
                    adv = 1'b1;
                end
                if (adv) begin
                    if (&r_q.scan) begin
                        clr_all  = 1'b1;
                        cmd_done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.scan = r_q.scan + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R2
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> $onehot0(hit_w));
    // R2
    rdy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid);
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
    // R11
    flush_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FLUSH && mem_valid) |-> mem_write);
    // R6
    evict_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EVICT) |-> (rd_valid[r_q.way] && rd_dirty[r_q.way]));
    // R9
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && req_valid && cfg_disable && !cmd_flush && !cmd_invalidate)
        |=> (r_q.st == ST_MEMOP && wr_en == '0));
endmodule

// File: tb/c2w_cache_tb_top.sv
`timescale 1ns/1ps
module c2w_cache_tb_top;
    localparam int AW = 24;
    localparam int SB = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_disable = 1'b0, cfg_write_back = 1'b1;
    logic cmd_invalidate = 1'b0, cmd_flush = 1'b0, cmd_done;
    logic req_valid = 1'b0, req_write = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0, mem_addr;
    logic [31:0] req_wdata = '0, req_rdata, mem_wdata, mem_rdata;
    logic [3:0] req_be = 4'hF, mem_be;
    logic mem_valid, mem_write, mem_ready;

    int nchk = 0, nerr = 0, nrd = 0, nwr = 0, stab_err = 0, wait_c = 0;
    logic [AW-1:0] last_wa, hold_a;
    logic [31:0] last_wd;
    logic pend = 1'b0, done_flag = 1'b0;
    logic [31:0] mem_m [int];

    always #2.5 clk = ~clk;

    c2w_cache #(.ADDR_W(AW), .SET_BITS(SB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_write_back(cfg_write_back),
        .cmd_invalidate(cmd_invalidate), .cmd_flush(cmd_flush), .cmd_done(cmd_done),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready), .req_rdata(req_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready), .mem_rdata(mem_rdata));

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction
    function automatic logic [31:0] pat(logic [AW-1:0] a);
        return 32'h5A000000 ^ {10'b0, a[AW-1:2]};
    endfunction
    function automatic logic [31:0] rdw(logic [AW-1:0] a);
        int k = int'(a[AW-1:2]);
        return mem_m.exists(k) ? mem_m[k] : pat(a);
    endfunction
    function automatic logic [AW-1:0] mk(int tag, int set);
        return {tag[AW-SB-3:0], set[SB-1:0], 2'b00};
    endfunction

    // memory model: completes each transaction after a two-cycle wait
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            wait_c = 0;
            pend = 1'b0;
        end else if (mem_valid && mem_ready) begin
            if (pend && mem_addr !== hold_a) stab_err++;
            if (mem_write) begin
                mem_m[int'(mem_addr[AW-1:2])] = merge(rdw(mem_addr), mem_wdata, mem_be);
                nwr++; last_wa = mem_addr; last_wd = mem_wdata;
            end else nrd++;
            mem_ready <= 1'b0;
            wait_c = 0;
            pend = 1'b0;
        end else if (mem_valid) begin
            if (pend && mem_addr !== hold_a) stab_err++;
            pend = 1'b1;
            hold_a = mem_addr;
            if (wait_c == 1) begin
                mem_ready <= 1'b1;
                mem_rdata <= rdw(mem_addr);
            end
            wait_c++;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [AW-1:0] a, input logic [31:0] wd,
                       input logic [3:0] be, output logic [31:0] rd, output int cyc);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd; req_be = be;
        cyc = 0;
        forever begin
            @(negedge clk); cyc++;
            if (req_ready) break;
        end
        rd = req_rdata;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic cmd(input logic flush);
        @(posedge clk); #1;
        if (flush) cmd_flush = 1'b1; else cmd_invalidate = 1'b1;
        forever begin
            @(negedge clk);
            if (cmd_done) break;
        end
        @(posedge clk); #1;
        cmd_flush = 1'b0; cmd_invalidate = 1'b0;
    endtask

    logic [31:0] rd, a1, e2, memE;
    int cyc, r0, w0;

    task automatic t_reset();
        @(negedge clk);
        check("R1 req_ready after reset", {31'b0, req_ready}, 32'd0);
        check("R1 mem_valid after reset", {31'b0, mem_valid}, 32'd0);
        check("R1 cmd_done after reset", {31'b0, cmd_done}, 32'd0);
    endtask

    task automatic t_miss_hit();
        r0 = nrd;
        acc(0, mk(1,1), 0, 4'hF, rd, cyc);
        check("R1 R3 first read fetches", nrd - r0, 1);
        check("R3 miss data", rd, pat(mk(1,1)));
        r0 = nrd;
        acc(0, mk(1,1) | 24'h3, 0, 4'hF, rd, cyc);
        check("R2 hit no memory read", nrd - r0, 0);
        check("R2 hit same cycle", cyc, 1);
        check("R2 hit data", rd, pat(mk(1,1)));
    endtask

    task automatic t_two_way_lru();
        acc(0, mk(2,1), 0, 4'hF, rd, cyc);
        r0 = nrd;
        acc(0, mk(1,1), 0, 4'hF, rd, cyc);
        check("R4 both ways resident", nrd - r0, 0);
        acc(0, mk(3,1), 0, 4'hF, rd, cyc);
        r0 = nrd;
        acc(0, mk(1,1), 0, 4'hF, rd, cyc);
        check("R5 recently used line kept", nrd - r0, 0);
        r0 = nrd;
        acc(0, mk(2,1), 0, 4'hF, rd, cyc);
        check("R5 least recently used evicted", nrd - r0, 1);
        acc(0, mk(1,1), 0, 4'hF, rd, cyc);
    endtask

    task automatic t_write_back();
        r0 = nrd; w0 = nwr;
        acc(1, mk(1,1), 32'hAABBCCDD, 4'b0011, rd, cyc);
        a1 = merge(pat(mk(1,1)), 32'hAABBCCDD, 4'b0011);
        check("R6 write hit no memory traffic", (nrd - r0) + (nwr - w0), 0);
        acc(0, mk(1,1), 0, 4'hF, rd, cyc);
        check("R6 merged bytes", rd, a1);
        check("R6 memory still old", rdw(mk(1,1)), pat(mk(1,1)));
        w0 = nwr;
        acc(0, mk(3,1), 0, 4'hF, rd, cyc);
        check("R6 clean victim not written", nwr - w0, 0);
        w0 = nwr;
        acc(0, mk(4,1), 0, 4'hF, rd, cyc);
        check("R6 dirty victim written once", nwr - w0, 1);
        check("R6 writeback address", last_wa, mk(1,1));
        check("R6 writeback data", last_wd, a1);
        check("R6 fill after writeback", rd, pat(mk(4,1)));
        r0 = nrd; w0 = nwr;
        acc(1, mk(5,2), 32'h11223344, 4'b1000, rd, cyc);
        check("R7 write miss fills", nrd - r0, 1);
        check("R7 write miss no memory write", nwr - w0, 0);
        acc(0, mk(5,2), 0, 4'hF, rd, cyc);
        check("R7 allocated merge", rd, merge(pat(mk(5,2)), 32'h11223344, 4'b1000));
    endtask

    task automatic t_write_through();
        cfg_write_back = 1'b0;
        w0 = nwr;
        acc(1, mk(5,2) | 24'h1, 32'h000000EE, 4'b0001, rd, cyc);
        check("R8 write hit reaches memory", nwr - w0, 1);
        check("R8 write address", last_wa, mk(5,2) | 24'h1);
        e2 = merge(merge(pat(mk(5,2)), 32'h11223344, 4'b1000), 32'h000000EE, 4'b0001);
        r0 = nrd;
        acc(0, mk(5,2), 0, 4'hF, rd, cyc);
        check("R8 cache updated on hit", rd, e2);
        check("R8 read hit no fetch", nrd - r0, 0);
        r0 = nrd; w0 = nwr;
        acc(1, mk(6,3), 32'hCAFEF00D, 4'hF, rd, cyc);
        check("R8 write miss to memory", nwr - w0, 1);
        check("R8 write miss no fill", nrd - r0, 0);
        r0 = nrd;
        acc(0, mk(6,3), 0, 4'hF, rd, cyc);
        check("R8 no allocation on write miss", nrd - r0, 1);
        check("R8 memory holds write", rd, 32'hCAFEF00D);
    endtask

    task automatic t_disable();
        cfg_disable = 1'b1;
        memE = rdw(mk(5,2));
        r0 = nrd;
        acc(0, mk(5,2), 0, 4'hF, rd, cyc);
        check("R9 bypass read fetches", nrd - r0, 1);
        check("R9 bypass data from memory", rd, memE);
        w0 = nwr;
        acc(1, mk(7,3), 32'h01020304, 4'hF, rd, cyc);
        check("R9 bypass write", nwr - w0, 1);
        cfg_disable = 1'b0;
        r0 = nrd;
        acc(0, mk(5,2), 0, 4'hF, rd, cyc);
        check("R9 line kept during bypass", nrd - r0, 0);
        check("R9 line contents kept", rd, e2);
    endtask

    task automatic t_invalidate();
        cfg_write_back = 1'b1;
        w0 = nwr;
        cmd(1'b0);
        check("R10 invalidate no write", nwr - w0, 0);
        r0 = nrd;
        acc(0, mk(5,2), 0, 4'hF, rd, cyc);
        check("R10 read misses after invalidate", nrd - r0, 1);
        check("R10 data from memory", rd, memE);
    endtask

    task automatic t_flush();
        acc(1, mk(8,0), 32'hDEADBEEF, 4'hF, rd, cyc);
        acc(1, mk(9,1), 32'h0BADCAFE, 4'hF, rd, cyc);
        w0 = nwr;
        cmd(1'b1);
        check("R11 dirty lines written", nwr - w0, 2);
        check("R11 first line in memory", rdw(mk(8,0)), 32'hDEADBEEF);
        check("R11 second line in memory", rdw(mk(9,1)), 32'h0BADCAFE);
        r0 = nrd;
        acc(0, mk(8,0), 0, 4'hF, rd, cyc);
        check("R11 cleared after flush", nrd - r0, 1);
        check("R11 reread data", rd, 32'hDEADBEEF);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_miss_hit();
        t_two_way_lru();
        t_write_back();
        t_write_through();
        t_disable();
        t_invalidate();
        t_flush();
        check("R12 memory request stable", stab_err, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule